// File: doc/BRIEF.md
# SPI Slave Register and FIFO Access Port

This block lets an external SPI master (clock polarity 0, phase 0) read and write a 128-entry space of 8-bit registers and a FIFO data port. The three SPI inputs are oversampled on a fast system clock. All decoding, address stepping and strobe generation happen in that clock domain. The register bank and the FIFO storage sit outside the block. The block drives a single address, one-cycle read and write strobes for the registers, and one-cycle push and pop strobes for the FIFO.

Each frame opens when the chip select goes low. The first byte is a command: its top bit selects write (1) or read (0), and its low seven bits give the start address. Every later byte in the same frame is data. Stopping after one data byte gives a single access. Keeping the chip select low gives a burst: the address steps by one after each byte, skips the FIFO address, and wraps from the top of the space. When the command names the FIFO address, every data byte goes to the FIFO port and the address stays where it is.

Read data must be on MISO before the master samples the first bit of a byte. For that reason the next read is fetched as soon as the previous byte completes, before the master has shown whether it will clock another byte. The system clock is expected to run at least 8 times faster than SCK, so that MISO settles after the synchronizer delay.

Top module: `spi_reg_bridge`

## Requirements
- R1: `miso_oe` is 0 out of reset and while NSS is high, and it is 1 from a few system clocks after NSS falls until a few clocks after NSS rises.
- R2: MOSI is sampled on rising SCK edges, MSB first. In the first byte of a frame, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6..0 are the address.
- R3: A write data byte produces exactly one `reg_wr_en` pulse of one clock, after all 8 bits have arrived. It carries `reg_addr` and `reg_wr_data` equal to the byte (MSB first).
- R4: In a read frame, one `reg_rd_en` pulse fires after the command byte. The byte it returns goes out on MISO MSB first, changing after falling SCK edges. MISO reads as 0x00 while the command byte is being clocked.
- R5: In a write burst, each further data byte is written to the previous address plus one.
- R6: In a read burst, each further byte returned is the register at the previous address plus one.
- R7: Address stepping skips the FIFO address (default 0x00). With the default, a burst that reaches 0x7F continues at 0x01. Register strobes never carry the FIFO address.
- R8: A write frame whose command address equals the FIFO address turns each data byte into one `fifo_push` pulse with `fifo_wdata` equal to the byte. No `reg_wr_en` fires and the address stays fixed.
- R9: A read frame on the FIFO address returns `fifo_rdata`, as seen in the `fifo_pop` cycle, for each byte. A read of N data bytes issues N+1 pops, because the last pop is fetched ahead. No `reg_rd_en` fires.
- R10: If NSS rises before the 8th bit of a byte, that byte is dropped with no strobe. The next frame decodes a new command byte.
- R11: No more than one of `reg_wr_en`, `reg_rd_en`, `fifo_push`, `fifo_pop` is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master |
| nss | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | MISO output enable; the pad is high impedance when 0 |
| reg_addr | output | 7 | Register or FIFO address for the current strobe |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_data | input | 8 | Register read data, combinational from `reg_addr` |
| fifo_push | output | 1 | One-cycle FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_pop | output | 1 | One-cycle FIFO read strobe |
| fifo_rdata | input | 8 | FIFO head data, valid in the `fifo_pop` cycle |

## Verification
The hardest case to reach is a byte dropped when the frame ends part-way through it. The bench drives a write command and four data bits, then raises NSS in the middle of the byte. It confirms that no strobe follows. It then reads the same address in a fresh frame and expects the preset value. The address wrap is reached by starting a write burst at 0x7E, so that three bytes land on 0x7E, 0x7F and then 0x01 while the FIFO stays untouched. A FIFO read burst checks the bytes returned and also counts the pops, including the one fetched ahead.

// File: rtl/spi_regif_pkg.sv
// Shared widths, the frame phase type and the burst address stepping rule.
package spi_regif_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned BIT_W  = $clog2(DATA_W);

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    // Next burst address: plus one, wrapping, never landing on the FIFO port.
    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] cur,
                                                    input logic [ADDR_W-1:0] fifo_a);
        logic [ADDR_W-1:0] n;
        n = cur + 1'b1;
        if (n == fifo_a) n = n + 1'b1;
        return n;
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
// Multi-flop synchronizer for a group of asynchronous input pins.
// Assumes the pins change slowly relative to clk; each bit has its own reset level.
module spi_pin_sync #(
    parameter int unsigned      N       = 3,
    parameter int unsigned      STAGES  = 2,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES-1:0] chain;
        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], pin[i]};
        end
        assign lvl[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_edge_det.sv
// Rising and falling edge pulses for one already-synchronized level.
module spi_edge_det #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;
    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_cmd_seq.sv
// Frame sequencer: counts bits on SCK rises, decodes the command byte,
// steps the address and issues one-cycle register / FIFO strobes.
// Assumes 'active' low clears the frame; strobes come one clock after a byte completes.
module spi_cmd_seq
    import spi_regif_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FIFO_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_rise,
    input  logic              mosi_lvl,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              mid_byte
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    phase_e            phase;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sr;
    logic              is_write;
    logic [ADDR_W-1:0] cur_addr;

    logic [DATA_W-1:0] rx_byte;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic              tgt_wr;
    logic              tgt_rd;

    assign rx_byte  = {rx_sr, mosi_lvl};
    assign mid_byte = (bit_cnt != '0);

    // Work out the target address and access kind of the byte now completing.
    always_comb begin
        nxt_addr = cur_addr;
        if (cur_addr != FIFO_ADDR) nxt_addr = step_addr(cur_addr, FIFO_ADDR);
        tgt_addr = cur_addr;
        tgt_wr   = 1'b0;
        tgt_rd   = 1'b0;
        if (phase == PH_CMD) begin
            tgt_addr = rx_byte[ADDR_W-1:0];
            tgt_rd   = ~rx_byte[DATA_W-1];
        end else if (is_write) begin
            tgt_addr = cur_addr;
            tgt_wr   = 1'b1;
        end else begin
            tgt_addr = nxt_addr;
            tgt_rd   = 1'b1;
        end
    end

    // Bit counting, command capture, address stepping and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            is_write  <= 1'b0;
            cur_addr  <= '0;
            port_addr <= '0;
            wr_data   <= '0;
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            fifo_push <= 1'b0;
            fifo_pop  <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            fifo_push <= 1'b0;
            fifo_pop  <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                phase   <= PH_CMD;
            end else if (sck_rise) begin
                rx_sr   <= rx_byte[DATA_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    if (phase == PH_CMD) begin
                        is_write <= rx_byte[DATA_W-1];
                        cur_addr <= rx_byte[ADDR_W-1:0];
                        phase    <= PH_DATA;
                    end else begin
                        cur_addr <= nxt_addr;
                    end
                    if (tgt_wr || tgt_rd) port_addr <= tgt_addr;
                    if (tgt_wr) begin
                        wr_data <= rx_byte;
                        if (tgt_addr == FIFO_ADDR) fifo_push <= 1'b1;
                        else                       reg_wr_en <= 1'b1;
                    end
                    if (tgt_rd) begin
                        if (tgt_addr == FIFO_ADDR) fifo_pop  <= 1'b1;
                        else                       reg_rd_en <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_tx_shift.sv
// MISO shifter: loads fetched read data, shifts on falling SCK inside a byte.
// Assumes a load never coincides with a falling edge (clk well above SCK).
module spi_tx_shift
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_fall,
    input  logic              mid_byte,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso_bit
);
    logic [DATA_W-1:0] tx_sr;
    // Clear between frames, load on fetch, shift after each sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tx_sr <= '0;
        else if (!active)               tx_sr <= '0;
        else if (load)                  tx_sr <= load_data;
        else if (sck_fall && mid_byte)  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end
    assign miso_bit = tx_sr[DATA_W-1];
endmodule

// File: rtl/spi_reg_bridge.sv
// Top: SPI mode-0 slave giving register and FIFO port access.
// Assumes clk at least 8x SCK; reg_rd_data is combinational from reg_addr and
// fifo_rdata shows the FIFO head in the fifo_pop cycle.
module spi_reg_bridge
    import spi_regif_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 7'h00,
    parameter int unsigned       SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              nss,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_pop,
    input  logic [DATA_W-1:0] fifo_rdata
);
    logic [2:0]        pin_lvl;
    logic              sck_rise, sck_fall;
    logic              active;
    logic              mid_byte;
    logic [DATA_W-1:0] wr_data;

    spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin({mosi, nss, sck}), .lvl(pin_lvl)
    );

    spi_edge_det #(.RST_VAL(1'b0)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[0]), .rise(sck_rise), .fall(sck_fall)
    );

    assign active = ~pin_lvl[1];

    spi_cmd_seq #(.FIFO_ADDR(FIFO_ADDR)) u_seq (
        .clk(clk), .rst_n(rst_n), .active(active), .sck_rise(sck_rise),
        .mosi_lvl(pin_lvl[2]), .port_addr(reg_addr), .wr_data(wr_data),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .fifo_push(fifo_push),
        .fifo_pop(fifo_pop), .mid_byte(mid_byte)
    );

    spi_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n), .active(active), .sck_fall(sck_fall),
        .mid_byte(mid_byte), .load(reg_rd_en | fifo_pop),
        .load_data(fifo_pop ? fifo_rdata : reg_rd_data), .miso_bit(miso)
    );

    assign miso_oe     = active;
    assign reg_wr_data = wr_data;
    assign fifo_wdata  = wr_data;
endmodule

// File: rtl/spi_reg_bridge_chk.sv
// Protocol checker for spi_reg_bridge, attached with bind below.
module spi_reg_bridge_chk
    import spi_regif_pkg::*;
#(
    parameter logic [ADDR_W-1:0] FIFO_ADDR = 7'h00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nss,
    input logic              miso_oe,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic              fifo_push,
    input logic              fifo_pop
);
    // R1: chip select held high for three clocks leaves the output disabled.
    p_oe_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nss, 1) && $past(nss, 2) && $past(nss, 3)) |-> !miso_oe);
    // R11: at most one strobe per cycle.
    p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en, reg_rd_en, fifo_push, fifo_pop}));
    // R3: write strobe lasts one cycle.
    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R9: pop strobe lasts one cycle.
    p_pop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);
    // R8: FIFO strobes always carry the FIFO address.
    p_fifo_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push || fifo_pop) |-> (reg_addr == FIFO_ADDR));
    // R7: register strobes never carry the FIFO address.
    p_reg_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> (reg_addr != FIFO_ADDR));
    // R10: write strobes only occur inside a frame.
    p_wr_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || fifo_push) |-> $past(miso_oe));
endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(.FIFO_ADDR(FIFO_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .nss(nss), .miso_oe(miso_oe), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .fifo_push(fifo_push),
    .fifo_pop(fifo_pop)
);

// File: tb/test_spi_reg_bridge.sv
`timescale 1ns/1ps
// Directed bench: a bench-side SPI master, register bank model and FIFO source.
module test_spi_reg_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sck = 1'b0, nss = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en, reg_rd_en, fifo_push, fifo_pop;
    logic [7:0] reg_wr_data, reg_rd_data, fifo_wdata, fifo_rdata;

    logic [7:0] regs [128];
    logic [7:0] pop_src = 8'hC0;
    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    logic [6:0] wr_addr_log [64];
    logic [7:0] wr_data_log [64];
    logic [7:0] push_log [64];
    int wr_cnt = 0, rd_cnt = 0, push_cnt = 0, pop_cnt = 0, multi_cnt = 0, oe_bad = 0;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_reg_bridge i_spi_reg_bridge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .nss(nss), .mosi(mosi), .miso(miso),
        .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata)
    );

    assign reg_rd_data = regs[reg_addr];
    assign fifo_rdata  = pop_src;

    initial for (int i = 0; i < 128; i++) regs[i] = 8'(i) ^ 8'h5A;

    // Register bank and FIFO source models.
    always @(posedge clk) begin
        if (reg_wr_en) regs[reg_addr] <= reg_wr_data;
        if (fifo_pop)  pop_src <= pop_src + 8'd1;
    end

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((32'(reg_wr_en) + 32'(reg_rd_en) + 32'(fifo_push) + 32'(fifo_pop)) > 1)
                multi_cnt++;
            if (reg_wr_en) begin
                wr_addr_log[wr_cnt % 64] = reg_addr;
                wr_data_log[wr_cnt % 64] = reg_wr_data;
                wr_cnt++;
            end
            if (fifo_push) begin
                push_log[push_cnt % 64] = fifo_wdata;
                push_cnt++;
            end
            if (reg_rd_en) rd_cnt++;
            if (fifo_pop)  pop_cnt++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Master frame: nbytes full bytes from tx_buf, then extra_bits partial bits.
    task automatic xfer(input int nbytes, input int extra_bits);
        nss = 1'b0;
        repeat (6) @(negedge clk);
        for (int b = 0; b < nbytes; b++) begin
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_buf[b][i];
                #(HALF);
                if (miso_oe !== 1'b1) oe_bad++;
                rx_buf[b][i] = miso;
                sck = 1'b1;
                #(HALF);
                sck = 1'b0;
            end
        end
        for (int i = 0; i < extra_bits; i++) begin
            mosi = 1'b1;
            #(HALF);
            sck = 1'b1;
            #(HALF);
            sck = 1'b0;
        end
        #(HALF);
        nss = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset oe", 32'(miso_oe), 0);
        chk("R11 reset strobes", 32'({reg_wr_en, reg_rd_en, fifo_push, fifo_pop}), 0);
    endtask

    task automatic t_single_write();
        int w0 = wr_cnt, p0 = push_cnt;
        tx_buf[0] = 8'h92; tx_buf[1] = 8'hA5;
        xfer(2, 0);
        chk("R3 single write count", 32'(wr_cnt - w0), 1);
        chk("R2 write address", 32'(wr_addr_log[w0 % 64]), 32'h12);
        chk("R3 write data", 32'(wr_data_log[w0 % 64]), 32'hA5);
        chk("R8 no push on register write", 32'(push_cnt - p0), 0);
        chk("R1 oe low after frame", 32'(miso_oe), 0);
    endtask

    task automatic t_single_read();
        tx_buf[0] = 8'h12; tx_buf[1] = 8'h00;
        xfer(2, 0);
        chk("R4 zeros during command", 32'(rx_buf[0]), 0);
        chk("R4 read data", 32'(rx_buf[1]), 32'hA5);
    endtask

    task automatic t_burst_write();
        int w0 = wr_cnt;
        tx_buf[0] = 8'hA0; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
        xfer(4, 0);
        chk("R5 burst count", 32'(wr_cnt - w0), 3);
        chk("R5 burst addr 1", 32'(wr_addr_log[(w0 + 1) % 64]), 32'h21);
        chk("R5 burst addr 2", 32'(wr_addr_log[(w0 + 2) % 64]), 32'h22);
        chk("R5 burst data 2", 32'(wr_data_log[(w0 + 2) % 64]), 32'h33);
    endtask

    task automatic t_burst_read();
        tx_buf[0] = 8'h20; tx_buf[1] = 0; tx_buf[2] = 0; tx_buf[3] = 0;
        xfer(4, 0);
        chk("R6 burst read 0", 32'(rx_buf[1]), 32'h11);
        chk("R6 burst read 1", 32'(rx_buf[2]), 32'h22);
        chk("R6 burst read 2", 32'(rx_buf[3]), 32'h33);
    endtask

    task automatic t_wrap();
        int w0 = wr_cnt, p0 = push_cnt;
        tx_buf[0] = 8'hFE; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02; tx_buf[3] = 8'h03;
        xfer(4, 0);
        chk("R7 wrap addr 0", 32'(wr_addr_log[w0 % 64]), 32'h7E);
        chk("R7 wrap addr 1", 32'(wr_addr_log[(w0 + 1) % 64]), 32'h7F);
        chk("R7 wrap addr 2 skips FIFO", 32'(wr_addr_log[(w0 + 2) % 64]), 32'h01);
        chk("R7 no FIFO push on wrap", 32'(push_cnt - p0), 0);
    endtask

    task automatic t_fifo_write();
        int w0 = wr_cnt, p0 = push_cnt;
        tx_buf[0] = 8'h80; tx_buf[1] = 8'hD1; tx_buf[2] = 8'hD2; tx_buf[3] = 8'hD3;
        xfer(4, 0);
        chk("R8 push count", 32'(push_cnt - p0), 3);
        chk("R8 push data 0", 32'(push_log[p0 % 64]), 32'hD1);
        chk("R8 push data 2", 32'(push_log[(p0 + 2) % 64]), 32'hD3);
        chk("R8 no register write", 32'(wr_cnt - w0), 0);
    endtask

    task automatic t_fifo_read();
        int q0 = pop_cnt, r0 = rd_cnt;
        logic [7:0] s0 = pop_src;
        tx_buf[0] = 8'h00; tx_buf[1] = 0; tx_buf[2] = 0;
        xfer(3, 0);
        chk("R9 pop data 0", 32'(rx_buf[1]), 32'(s0));
        chk("R9 pop data 1", 32'(rx_buf[2]), 32'(s0 + 8'd1));
        chk("R9 pop count with prefetch", 32'(pop_cnt - q0), 3);
        chk("R9 no register read", 32'(rd_cnt - r0), 0);
    endtask

    task automatic t_abort();
        int w0 = wr_cnt;
        tx_buf[0] = 8'hC0;
        xfer(1, 4);
        chk("R10 no write on partial byte", 32'(wr_cnt - w0), 0);
        tx_buf[0] = 8'h40; tx_buf[1] = 8'h00;
        xfer(2, 0);
        chk("R10 register unchanged", 32'(rx_buf[1]), 32'h1A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_single_write();
        t_single_read();
        t_burst_write();
        t_burst_read();
        t_wrap();
        t_fifo_write();
        t_fifo_read();
        t_abort();
        chk("R1 oe high during every bit", 32'(oe_bad), 0);
        chk("R11 strobe overlap", 32'(multi_cnt), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule